// File: doc/BRIEF.md
# Modulated Direct Digital Synthesizer

This block is a single-channel numerically controlled oscillator that feeds a DAC with one signed sine sample per clock. A wide phase register advances on every clock by a tuning word plus a signed, per-clock frequency offset. The offset lets a neighbouring block apply frequency modulation or sweep the frequency linearly as a chirp. The output frequency is the tuning word times Fclk / 2^PH_W, so a 32-bit register at 128 MHz tunes in steps of about 0.03 Hz.

The top address bits of the phase go through a rotation adder and then index a sine table. The table is filled at elaboration by a constant function, so no external file is read. The looked-up sample is then scaled by an amplitude word. A square wave is taken from the phase MSB and kept in step with the sample stream. Its edges fall on clock edges, so its cycle-to-cycle jitter is one clock peak to peak. A load strobe can overwrite the phase, for example to restart a burst at a known phase.

Top module: `dds_fm_synth`

## Requirements
- R1: During each clock cycle with `rst` and `phase_ld` low, the phase register advances by `tune_word` modulo 2^32, so the phase after k cycles is P0 + k*tune_word.
- R2: `fm_offset` is a signed two's-complement word that is added to `tune_word` in the same cycle. A negative offset slows the phase advance. The sum wraps modulo 2^32.
- R3: When `phase_ld` is high in a cycle, the phase held in the next cycle is `phase_ld_val`, whatever the tuning word and the offset are. A load takes priority over the increment.
- R4: The table address is the top 12 phase bits plus `phase_rot`, modulo 4096. The rotation changes only the output. The accumulator keeps advancing as if no rotation were applied.
- R5: For table address a and full-scale amplitude, the table value is round(8191 * sin(2*pi*(a + 0.5)/4096)), within 1 LSB. The value lies in -8191..8191 and is never -8192.
- R6: `sample_out` = trunc_toward_zero(T * `amp_word` / 16384), where T is the table value and `amp_word` is unsigned. An amplitude of zero gives zero.
- R7: The sample and square values for a phase value held in cycle c appear on the outputs in cycle c+3. They use the `phase_rot` and `amp_word` values presented in cycle c. `out_vld` is low for the first three cycles after reset is released and high from the fourth cycle on.
- R8: `square_out` is bit 31 of the unrotated phase, delayed by the same three cycles as the sample.
- R9: The synchronous, active-high `rst` clears the phase to zero. While it is held, `out_vld`, `sample_out` and `square_out` are zero.
- R10: With a zero increment (`tune_word` + `fm_offset` = 0), no load and fixed controls, the outputs stay constant from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Base phase increment per clock |
| fm_offset | input | 32 | Signed increment offset for FM or chirp |
| phase_ld | input | 1 | Load strobe for the phase register |
| phase_ld_val | input | 32 | Phase value written on a load |
| phase_rot | input | 12 | Rotation added to the table address |
| amp_word | input | 14 | Unsigned amplitude, full scale 16383 |
| sample_out | output | 14 | Signed scaled sine sample |
| square_out | output | 1 | Phase-MSB square wave, aligned with the samples |
| out_vld | output | 1 | High once the pipeline holds valid data |

## Verification
Every result is due exactly three cycles after the cycle in which the corresponding phase, rotation and amplitude were held. A phase load shows up one cycle later, on the output of cycle c+4. The driver task keeps its own model of the phase and pushes one expected sample and square value per driven cycle. The monitor pops one entry for each cycle in which `out_vld` is high, so any latency error shifts the whole stream and is caught. The first four cycles after reset release are checked individually for the `out_vld` rise, and the queue must be empty once the run has drained.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

   // Pipeline depth from a held phase value to the output ports.
   localparam int PIPE_LAT = 3;

   // Fixed-point resolution used by the elaboration-time sine evaluation.
   localparam int FRAC = 28;
   localparam longint PI_FX = 64'sd843314857;   // pi * 2^28, rounded

   // Magnitude of sin(pi*(2k+1)/2^aw) scaled to (2^(sw-1))-1, rounded.
   // k is a first-quadrant index (0 .. 2^(aw-2)-1).
   function automatic int quarter_mag(input int unsigned k,
                                      input int unsigned aw,
                                      input int unsigned sw);
      longint x;
      longint x2;
      longint term;
      longint acc;
      longint peak;
      x    = (PI_FX * longint'(2 * k + 1)) >>> aw;
      x2   = (x * x) >>> FRAC;
      term = x;
      acc  = x;
      for (int n = 1; n < 9; n++) begin
         term = (-((term * x2) >>> FRAC)) / longint'((2 * n) * (2 * n + 1));
         acc  = acc + term;
      end
      peak = (longint'(1) << (sw - 1)) - 1;
      return int'((acc * peak + (longint'(1) << (FRAC - 1))) >>> FRAC);
   endfunction

endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
   parameter int PH_W   = 32,
   parameter int ADDR_W = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [PH_W-1:0]          tune,
   input  logic signed [PH_W-1:0]   fm,
   input  logic                     ld,
   input  logic [PH_W-1:0]          ld_val,
   output logic [ADDR_W-1:0]        ph_top
);

   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] step;

   // Effective increment wraps modulo 2^PH_W; signed offset is two's complement.
   assign step = tune + $unsigned(fm);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q <= '0;
      end else if (ld) begin
         ph_q <= ld_val;
      end else begin
         ph_q <= ph_q + step;
      end
   end

   assign ph_top = ph_q[PH_W-1 -: ADDR_W];

endmodule

// File: rtl/dds_sine_rom.sv
`timescale 1ns/1ps
module dds_sine_rom #(
   parameter int ADDR_W      = 12,
   parameter int SAMP_W      = 14,
   parameter bit QUARTER_ROM = 1'b1
) (
   input  logic                     clk,
   input  logic [ADDR_W-1:0]        addr,
   output logic signed [SAMP_W-1:0] samp
);

   localparam int MAG_W  = SAMP_W - 1;
   localparam int DEPTH  = 2 ** ADDR_W;
   localparam int QDEPTH = 2 ** (ADDR_W - 2);
   localparam int QA_W   = ADDR_W - 2;

   generate
      if (QUARTER_ROM) begin : g_quarter
         logic [MAG_W-1:0]         qrom [QDEPTH];
         logic [QA_W-1:0]          qidx;
         logic signed [SAMP_W-1:0] pos;

         for (genvar g = 0; g < QDEPTH; g++) begin : g_fill
            assign qrom[g] = MAG_W'(dds_pkg::quarter_mag(g, ADDR_W, SAMP_W));
         end

         // Second and fourth quadrants read the table mirrored; the
         // half-step phase offset makes the mirror a plain bit inversion.
         assign qidx = addr[ADDR_W-2] ? ~addr[QA_W-1:0] : addr[QA_W-1:0];
         assign pos  = $signed({1'b0, qrom[qidx]});

         always_ff @(posedge clk) begin
            samp <= addr[ADDR_W-1] ? -pos : pos;
         end
      end else begin : g_full
         logic signed [SAMP_W-1:0] from [DEPTH];

         for (genvar g = 0; g < DEPTH; g++) begin : g_fill
            localparam int QI  = (((g >> QA_W) & 1) != 0) ? (QDEPTH - 1 - (g % QDEPTH))
                                                          : (g % QDEPTH);
            localparam int MAG = dds_pkg::quarter_mag(QI, ADDR_W, SAMP_W);
            localparam bit NEG = ((g >> (ADDR_W - 1)) & 1) != 0;
            assign from[g] = NEG ? SAMP_W'(-MAG) : SAMP_W'(MAG);
         end

         always_ff @(posedge clk) begin
            samp <= from[addr];
         end
      end
   endgenerate

endmodule

// File: rtl/dds_amp_scale.sv
`timescale 1ns/1ps
module dds_amp_scale #(
   parameter int SAMP_W = 14,
   parameter int AMP_W  = 14
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [SAMP_W-1:0] samp,
   input  logic [AMP_W-1:0]         amp,
   output logic signed [SAMP_W-1:0] y
);

   localparam int P_W = SAMP_W + AMP_W + 1;
   localparam logic signed [P_W-1:0] BIAS = P_W'((64'd1 << AMP_W) - 64'd1);

   logic signed [P_W-1:0] sx;
   logic signed [P_W-1:0] ax;
   logic signed [P_W-1:0] prod;
   logic signed [P_W-1:0] biased;

   assign sx   = P_W'(samp);
   assign ax   = $signed(P_W'({1'b0, amp}));
   assign prod = sx * ax;

   // Negative products get a bias so the arithmetic shift rounds toward zero.
   assign biased = prod[P_W-1] ? (prod + BIAS) : prod;

   always_ff @(posedge clk) begin
      if (rst) begin
         y <= '0;
      end else begin
         y <= SAMP_W'(biased >>> AMP_W);
      end
   end

endmodule

// File: rtl/dds_fm_synth.sv
`timescale 1ns/1ps
module dds_fm_synth #(
   parameter int PH_W        = 32,
   parameter int ADDR_W      = 12,
   parameter int SAMP_W      = 14,
   parameter int AMP_W       = 14,
   parameter bit QUARTER_ROM = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [PH_W-1:0]          tune_word,
   input  logic signed [PH_W-1:0]   fm_offset,
   input  logic                     phase_ld,
   input  logic [PH_W-1:0]          phase_ld_val,
   input  logic [ADDR_W-1:0]        phase_rot,
   input  logic [AMP_W-1:0]         amp_word,
   output logic signed [SAMP_W-1:0] sample_out,
   output logic                     square_out,
   output logic                     out_vld
);

   localparam int LAT = dds_pkg::PIPE_LAT;

   // Elaboration-time parameter checks.
   generate
      if (PH_W < ADDR_W) begin : g_bad_ph
         $error("dds_fm_synth: PH_W must be at least ADDR_W");
      end
      if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_addr
         $error("dds_fm_synth: ADDR_W must lie in 3..16");
      end
      if (SAMP_W < 4 || SAMP_W > 24) begin : g_bad_samp
         $error("dds_fm_synth: SAMP_W must lie in 4..24");
      end
      if (AMP_W < 2 || AMP_W > 24) begin : g_bad_amp
         $error("dds_fm_synth: AMP_W must lie in 2..24");
      end
   endgenerate

   logic [ADDR_W-1:0]        phase_top;
   logic [ADDR_W-1:0]        addr_s1;
   logic [AMP_W-1:0]         amp_s1;
   logic [AMP_W-1:0]         amp_s2;
   logic                     sq_s1;
   logic                     sq_s2;
   logic                     sq_s3;
   logic signed [SAMP_W-1:0] samp_s2;
   logic [LAT-1:0]           vld_sr;

   dds_phase_acc #(
      .PH_W   (PH_W),
      .ADDR_W (ADDR_W)
   ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .tune   (tune_word),
      .fm     (fm_offset),
      .ld     (phase_ld),
      .ld_val (phase_ld_val),
      .ph_top (phase_top)
   );

   // Stage 1: rotate the address, capture amplitude and MSB with it.
   always_ff @(posedge clk) begin
      if (rst) begin
         addr_s1 <= '0;
         amp_s1  <= '0;
         sq_s1   <= 1'b0;
      end else begin
         addr_s1 <= phase_top + phase_rot;
         amp_s1  <= amp_word;
         sq_s1   <= phase_top[ADDR_W-1];
      end
   end

   // Stage 2: table lookup (registered inside the ROM).
   dds_sine_rom #(
      .ADDR_W      (ADDR_W),
      .SAMP_W      (SAMP_W),
      .QUARTER_ROM (QUARTER_ROM)
   ) u_rom (
      .clk  (clk),
      .addr (addr_s1),
      .samp (samp_s2)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         amp_s2 <= '0;
         sq_s2  <= 1'b0;
         sq_s3  <= 1'b0;
      end else begin
         amp_s2 <= amp_s1;
         sq_s2  <= sq_s1;
         sq_s3  <= sq_s2;
      end
   end

   // Stage 3: amplitude scaling.
   dds_amp_scale #(
      .SAMP_W (SAMP_W),
      .AMP_W  (AMP_W)
   ) u_scale (
      .clk  (clk),
      .rst  (rst),
      .samp (samp_s2),
      .amp  (amp_s2),
      .y    (sample_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_sr <= '0;
      end else begin
         vld_sr <= {vld_sr[LAT-2:0], 1'b1};
      end
   end

   assign out_vld    = vld_sr[LAT-1];
   assign square_out = sq_s3;

endmodule

// File: rtl/dds_fm_synth_chk.sv
`timescale 1ns/1ps
module dds_fm_synth_chk #(
   parameter int SAMP_W = 14,
   parameter int AMP_W  = 14
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     phase_ld,
   input logic                     ld_msb,
   input logic                     phase_msb,
   input logic [AMP_W-1:0]         amp_word,
   input logic signed [SAMP_W-1:0] sample_out,
   input logic                     square_out,
   input logic                     out_vld
);

   localparam logic signed [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (!out_vld && sample_out == '0 && !square_out)); // R9

   AST_VLD_STAYS: assert property (@(posedge clk) disable iff (rst)
      out_vld |=> out_vld); // R7

   AST_SQ_ALIGN: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (square_out == $past(phase_msb, 3))); // R8

   AST_LOAD_SEEN: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(phase_ld, 4) && !$past(rst, 4)) |-> (square_out == $past(ld_msb, 4))); // R3

   AST_AMP_NULL: assert property (@(posedge clk) disable iff (rst)
      (out_vld && $past(amp_word, 3) == '0) |-> (sample_out == '0)); // R6

   AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (sample_out != MOST_NEG)); // R5

endmodule

bind dds_fm_synth dds_fm_synth_chk #(
   .SAMP_W (SAMP_W),
   .AMP_W  (AMP_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .phase_ld   (phase_ld),
   .ld_msb     (phase_ld_val[PH_W-1]),
   .phase_msb  (phase_top[ADDR_W-1]),
   .amp_word   (amp_word),
   .sample_out (sample_out),
   .square_out (square_out),
   .out_vld    (out_vld)
);

// File: tb/sim_dds_fm_synth.sv
`timescale 1ns/1ps
module sim_dds_fm_synth;

   typedef struct {
      int    s;
      bit    sq;
      string tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [31:0]        tune_word = '0;
   logic signed [31:0] fm_offset = '0;
   logic               phase_ld = 1'b0;
   logic [31:0]        phase_ld_val = '0;
   logic [11:0]        phase_rot = '0;
   logic [13:0]        amp_word = '0;
   logic signed [13:0] sample_out;
   logic               square_out;
   logic               out_vld;

   exp_t        sb[$];
   int          n_chk  = 0;
   int          n_fail = 0;
   logic [31:0] mdl_ph = '0;
   int          since  = 0;
   bit          ended  = 1'b0;

   always #2 clk = ~clk;

   dds_fm_synth u0 (
      .clk          (clk),
      .rst          (rst),
      .tune_word    (tune_word),
      .fm_offset    (fm_offset),
      .phase_ld     (phase_ld),
      .phase_ld_val (phase_ld_val),
      .phase_rot    (phase_rot),
      .amp_word     (amp_word),
      .sample_out   (sample_out),
      .square_out   (square_out),
      .out_vld      (out_vld)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   function automatic int ref_samp(input logic [11:0] a, input logic [13:0] amp);
      real r;
      int  s;
      r = 8191.0 * $sin(3.14159265358979 * (2.0 * a + 1.0) / 4096.0);
      s = (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
      return (s * int'(amp)) / 16384;
   endfunction

   // Driver: one call per clock cycle; pushes the expected result for the
   // phase held in that cycle, then advances the reference phase.
   task automatic step(input logic [31:0] tw, input logic [31:0] fm, input bit ld,
                       input logic [31:0] lv, input logic [11:0] rot,
                       input logic [13:0] amp, input string tag);
      logic [11:0] a;
      @(posedge clk);
      #1;
      rst          = 1'b0;
      tune_word    = tw;
      fm_offset    = fm;
      phase_ld     = ld;
      phase_ld_val = lv;
      phase_rot    = rot;
      amp_word     = amp;
      a = mdl_ph[31:20] + rot;
      sb.push_back('{ref_samp(a, amp), mdl_ph[31], tag});
      mdl_ph = ld ? lv : (mdl_ph + tw + fm);
   endtask

   // Monitor
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && !ended) begin
            if (since < 4) begin
               chk(out_vld == (since >= 3), "R7", int'(out_vld), int'(since >= 3));
            end
            since++;
            if (out_vld && sb.size() > 0) begin
               exp_t e;
               int   d;
               e = sb.pop_front();
               d = int'(sample_out) - e.s;
               chk(d >= -1 && d <= 1, e.tag, int'(sample_out), e.s);
               chk(square_out == e.sq, "R8", int'(square_out), int'(e.sq));
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R7: watchdog expired, actual 1 expected 0");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(out_vld == 1'b0, "R9", int'(out_vld), 0);
      chk(sample_out == 0, "R9", int'(sample_out), 0);
      chk(square_out == 1'b0, "R9", int'(square_out), 0);

      // R5: one address step per clock sweeps the whole table at full scale
      for (int i = 0; i < 4100; i++) step(32'h0010_0000, 32'h0, 1'b0, 32'h0, 12'h0, 14'h3FFF, "R5");

      // R1: odd tuning word, fine bits carried through the accumulator
      for (int i = 0; i < 300; i++) step(32'h0123_4567, 32'h0, 1'b0, 32'h0, 12'h0, 14'h3FFF, "R1");

      // R6: amplitude sweep including zero
      for (int i = 0; i < 300; i++) step(32'h0345_6789, 32'h0, 1'b0, 32'h0, 12'h0,
                                         14'((i * 97) % 16384), "R6");
      for (int i = 0; i < 8; i++) step(32'h0345_6789, 32'h0, 1'b0, 32'h0, 12'h0, 14'h0, "R6");

      // R2: chirp, negative offset rising through zero
      for (int i = 0; i < 300; i++) step(32'h0100_0000, 32'(-32'sd8388608 + i * 65536),
                                         1'b0, 32'h0, 12'h0, 14'h3FFF, "R2");

      // R4: rotation varies while the accumulator keeps running, then clears
      for (int i = 0; i < 200; i++) step(32'h0050_0000, 32'h0, 1'b0, 32'h0, 12'(i * 37),
                                         14'h3FFF, "R4");
      for (int i = 0; i < 50; i++) step(32'h0050_0000, 32'h0, 1'b0, 32'h0, 12'h0, 14'h3FFF, "R4");

      // R10: zero net increment holds the output constant
      for (int i = 0; i < 50; i++) step(32'h0070_0000, 32'hFF90_0000, 1'b0, 32'h0, 12'h005,
                                        14'h2AAA, "R10");

      // R3: periodic loads override the increment
      for (int i = 0; i < 200; i++) step(32'h0020_0000, 32'h0, (i % 20) == 7,
                                         32'(i * 32'h1357_9BDF), 12'h0, 14'h3FFF, "R3");

      // R8: fast square wave (16-cycle period)
      for (int i = 0; i < 64; i++) step(32'h1000_0000, 32'h0, 1'b0, 32'h0, 12'h0, 14'h3FFF, "R8");

      repeat (6) @(posedge clk);
      @(negedge clk);
      chk(sb.size() == 0, "R7", sb.size(), 0);
      if (!ended) begin
         ended = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule